// File: doc/BRIEF.md
# Flash Program/Erase Busy Status Engine

This block stands in for the internal write engine of a parallel byte-wide flash as a host sees it on the read bus. A one-cycle start pulse launches either a byte program (address, new data and the current contents of that byte) or a whole-array erase. A cycle counter then models the operation time. For that whole time an active-low ready/busy line is pulled low through an output enable, so several such lines can be wired together as an open-drain net.

While the engine is busy, reads are not plain array reads. The top data bit carries a polling flag. The bit below it flips once per read strobe, so software can see progress. When the timer expires, the engine emits a one-cycle commit strobe with the address and the final byte value. The array itself is written outside this block. Pulling the reset input low aborts the operation, floats the read data and drops the busy line, and nothing is committed.

The controller has four states. `ST_IDLE` waits for a start pulse. `ST_PROG` and `ST_ERASE` count down the operation time. `ST_FINISH` lasts one cycle and presents the commit strobe. The named transitions are:
- accept-program: from idle or finish into `ST_PROG`.
- accept-erase: from idle or finish into `ST_ERASE`.
- expire: from either busy state into `ST_FINISH` when the counter reaches zero.
- settle: from finish back to idle when no start is present.
- abort: from any state to idle, taken asynchronously when reset goes low.

Top module: `flash_busy_engine`

## Requirements
- R1: While `rst_n` is low, `rd_data_oe`, `ryby_oe`, `commit_valid` and `op_done` are 0. An operation under way when reset falls is dropped and never committed.
- R2: A `prog_start` pulse seen in idle or finish makes the engine busy for exactly `PROG_CYCLES` clock cycles, beginning in the cycle after the pulse.
- R3: An `erase_start` pulse seen in idle or finish makes the engine busy for exactly `ERASE_CYCLES` cycles, beginning in the cycle after the pulse.
- R4: While busy, `ryby_oe` is 1 and `ryby_n` is 0. Otherwise `ryby_oe` is 0 and `ryby_n` is 1.
- R5: In the single cycle after a program's busy time ends, `commit_valid` and `op_done` are 1, `commit_erase` is 0, `commit_addr` is the program address, and `commit_data` is the old byte ANDed with the new byte. A program therefore only clears bits.
- R6: In the single cycle after an erase's busy time ends, `commit_valid`, `op_done` and `commit_erase` are 1 and `commit_data` is all ones.
- R7: During a program, a read of the pending address returns the inverse of the new data's bit DW-1 on bit DW-1. A read of any other address returns the array's bit DW-1. During an erase, bit DW-1 reads 0.
- R8: A read strobe is a rising edge of `rd_en` at a clock edge. While busy, the status bit DW-2 is cleared when an operation starts and inverts on each strobe. It is visible on `rd_data[DW-2]` from the cycle after the strobe.
- R9: `rd_data_oe` equals `rd_en` while out of reset. When the engine is not busy, `rd_data` equals `arr_rdata`. While busy, bits DW-3..0 still equal `arr_rdata`.
- R10: Start pulses that arrive while busy are ignored. They change neither the timing nor the committed address and data.
- R11: When `prog_start` and `erase_start` arrive in the same cycle, the program is taken.
- R12: A start pulse given during the finish cycle is accepted, so the engine is busy again in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset and abort |
| prog_start | input | 1 | One-cycle pulse that starts a byte program |
| prog_addr | input | AW | Byte address to program |
| prog_data | input | DW | New byte value |
| prog_old | input | DW | Present contents of the byte at prog_addr |
| erase_start | input | 1 | One-cycle pulse that starts a whole-array erase |
| rd_en | input | 1 | Read enable; each rising edge is one read strobe |
| rd_addr | input | AW | Read address |
| arr_rdata | input | DW | Array contents at rd_addr |
| rd_data | output | DW | Read data with status override while busy |
| rd_data_oe | output | 1 | Read data drive enable; 0 means high impedance |
| ryby_n | output | 1 | Ready/busy level, low while busy |
| ryby_oe | output | 1 | Open-drain pull-down enable for the ready/busy line |
| op_done | output | 1 | One-cycle completion pulse |
| commit_valid | output | 1 | One-cycle array write strobe |
| commit_erase | output | 1 | Qualifies the commit as a whole-array erase |
| commit_addr | output | AW | Address to write for a program commit |
| commit_data | output | DW | Byte value to write |

## Verification
The assertions assume that `prog_start` and `erase_start` are single-cycle pulses sampled on the clock. They also assume that `prog_old` truly reflects the array at `prog_addr` when the pulse arrives. The bench meets both: it drives every input one time step after a rising edge and reads `prog_old` from its own array copy at that moment. That copy is updated only by the engine's commit strobe. Read strobes are spaced by at least one low cycle, so each one is a clean rising edge.

// File: rtl/flash_busy_pkg.sv
package flash_busy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROG   = 2'd1,
        ST_ERASE  = 2'd2,
        ST_FINISH = 2'd3
    } eng_state_t;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_t;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CW    = 8,
    parameter int LIMIT = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT)); // R2

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/flash_busy_readmux.sv
module flash_busy_readmux #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          op_start,
    input  logic          poll_prog,
    input  logic [AW-1:0] pend_addr,
    input  logic          pend_msb,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_data_oe
);

    localparam int POLL_BIT   = DW - 1;
    localparam int TOGGLE_BIT = DW - 2;

    logic rd_en_q;
    logic tgl_q;
    logic strobe;

    assign strobe = rd_en && !rd_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_en_q <= 1'b0;
            tgl_q   <= 1'b0;
        end else begin
            rd_en_q <= rd_en;
            if (op_start) begin
                tgl_q <= 1'b0;
            end else if (busy && strobe) begin
                tgl_q <= ~tgl_q;
            end
        end
    end

    always_comb begin
        rd_data_oe = rst_n && rd_en;
        rd_data    = '0;
        if (rd_data_oe) begin
            rd_data = arr_rdata;
            if (busy) begin
                rd_data[TOGGLE_BIT] = tgl_q;
                if (poll_prog) begin
                    rd_data[POLL_BIT] = (rd_addr == pend_addr) ? ~pend_msb
                                                               : arr_rdata[POLL_BIT];
                end else begin
                    rd_data[POLL_BIT] = 1'b0;
                end
            end
        end
    end

    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !op_start) |=> $stable(tgl_q)); // R8

    AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && strobe && !op_start) |=> (tgl_q != $past(tgl_q))); // R8

    AST_FLOAT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> !rd_data_oe); // R9

endmodule

// File: rtl/flash_busy_engine.sv
module flash_busy_engine
    import flash_busy_pkg::*;
#(
    parameter int AW           = 20,
    parameter int DW           = 8,
    parameter int PROG_CYCLES  = 500,
    parameter int ERASE_CYCLES = 100000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_start,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic [DW-1:0] prog_old,
    input  logic          erase_start,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_data_oe,
    output logic          ryby_n,
    output logic          ryby_oe,
    output logic          op_done,
    output logic          commit_valid,
    output logic          commit_erase,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);

    localparam int LONGEST    = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW         = $clog2(LONGEST + 1);
    localparam int LIMIT      = LONGEST - 1;
    localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

    eng_state_t    state_q, state_nxt;
    op_kind_t      kind_q;
    logic [AW-1:0] pend_addr_q;
    logic [DW-1:0] pend_data_q;
    logic [DW-1:0] pend_old_q;
    logic          accept;
    logic          busy;
    logic          expired;
    logic [CW-1:0] load_val;

    // a new operation may only be launched from idle or from the finish cycle
    assign accept   = ((state_q == ST_IDLE) || (state_q == ST_FINISH)) &&
                      (prog_start || erase_start);
    assign load_val = prog_start ? PROG_LOAD : ERASE_LOAD;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (prog_start) begin
                    state_nxt = ST_PROG;
                end else if (erase_start) begin
                    state_nxt = ST_ERASE;
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (expired) begin
                    state_nxt = ST_FINISH;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // pending operation capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q      <= OP_PROG;
            pend_addr_q <= '0;
            pend_data_q <= '0;
            pend_old_q  <= '0;
        end else if (accept) begin
            if (prog_start) begin
                kind_q      <= OP_PROG;
                pend_addr_q <= prog_addr;
                pend_data_q <= prog_data;
                pend_old_q  <= prog_old;
            end else begin
                kind_q      <= OP_ERASE;
                pend_addr_q <= '0;
                pend_data_q <= '1;
                pend_old_q  <= '1;
            end
        end
    end

    // outputs
    always_comb begin
        busy         = 1'b0;
        commit_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PROG:   busy = 1'b1;
            ST_ERASE:  busy = 1'b1;
            ST_FINISH: commit_valid = 1'b1;
            default:   ;
        endcase
        ryby_oe      = busy;
        ryby_n       = ~busy;
        op_done      = commit_valid;
        commit_erase = commit_valid && (kind_q == OP_ERASE);
        commit_addr  = pend_addr_q;
        commit_data  = (kind_q == OP_ERASE) ? {DW{1'b1}} : (pend_old_q & pend_data_q);
    end

    flash_busy_timer #(
        .CW    (CW),
        .LIMIT (LIMIT)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_val),
        .run      (busy),
        .expired  (expired)
    );

    flash_busy_readmux #(
        .AW (AW),
        .DW (DW)
    ) readmux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .op_start   (accept),
        .poll_prog  (state_q == ST_PROG),
        .pend_addr  (pend_addr_q),
        .pend_msb   (pend_data_q[DW-1]),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .arr_rdata  (arr_rdata),
        .rd_data    (rd_data),
        .rd_data_oe (rd_data_oe)
    );

    AST_COMMIT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> $past(ryby_oe)); // R5

    AST_BUSY_ENDS_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ryby_oe |=> (ryby_oe || commit_valid)); // R4

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !commit_erase) |-> ((commit_data & ~pend_old_q) == '0)); // R5

    AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_erase) |-> (&commit_data)); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ryby_oe && (prog_start || erase_start)) |=> ($stable(pend_addr_q) && $stable(kind_q))); // R10

endmodule

// File: tb/flash_busy_engine_tb.sv
module flash_busy_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int PC = 6;
    localparam int EC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [DW-1:0] prog_data = '0;
    logic [DW-1:0] prog_old = '0;
    logic          erase_start = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] rd_data;
    logic          rd_data_oe, ryby_n, ryby_oe, op_done;
    logic          commit_valid, commit_erase;
    logic [AW-1:0] commit_addr;
    logic [DW-1:0] commit_data;

    logic [DW-1:0] mem [0:(1<<AW)-1];
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // behavioural model state
    int            m_mode = 0;   // 0 idle, 1 program, 2 erase, 3 finish
    int            m_left = 0;
    bit            m_tgl = 0;
    bit            m_rdprev = 0;
    bit            m_fin_erase = 0;
    logic [AW-1:0] m_paddr = '0;
    logic [DW-1:0] m_pdata = '0;
    logic [DW-1:0] m_pold = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign arr_rdata = mem[rd_addr];

    flash_busy_engine #(
        .AW(AW), .DW(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_addr(prog_addr),
        .prog_data(prog_data), .prog_old(prog_old), .erase_start(erase_start),
        .rd_en(rd_en), .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
        .rd_data_oe(rd_data_oe), .ryby_n(ryby_n), .ryby_oe(ryby_oe), .op_done(op_done),
        .commit_valid(commit_valid), .commit_erase(commit_erase),
        .commit_addr(commit_addr), .commit_data(commit_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // array write from the engine's commit strobe, then the reference model step
    always @(posedge clk) begin
        bit strobe;
        if (commit_valid) begin
            if (commit_erase) begin
                for (int i = 0; i < (1<<AW); i++) mem[i] = '1;
            end else begin
                mem[commit_addr] = commit_data;
            end
        end
        if (!rst_n) begin
            m_mode = 0; m_tgl = 0; m_rdprev = 0;
        end else begin
            strobe = rd_en && !m_rdprev;
            m_rdprev = rd_en;
            if (m_mode == 1 || m_mode == 2) begin
                if (strobe) m_tgl = ~m_tgl;
                m_left--;
                if (m_left == 0) begin
                    m_fin_erase = (m_mode == 2);
                    m_mode = 3;
                end
            end else if (prog_start) begin
                m_mode = 1; m_left = PC; m_tgl = 0;
                m_paddr = prog_addr; m_pdata = prog_data; m_pold = prog_old;
            end else if (erase_start) begin
                m_mode = 2; m_left = EC; m_tgl = 0;
            end else begin
                m_mode = 0;
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        bit            busy_e, fin_e;
        string         rtag;
        logic [DW-1:0] e;
        busy_e = rst_n && (m_mode == 1 || m_mode == 2);
        fin_e  = rst_n && (m_mode == 3);
        rtag   = !rst_n ? "R1" : (m_mode == 1) ? "R2" : (m_mode == 2) ? "R3" : "R4";
        chk(rtag, ryby_oe, busy_e);
        chk("R4", ryby_n, !busy_e);
        chk(m_fin_erase ? "R6" : "R5", commit_valid, fin_e);
        chk(m_fin_erase ? "R6" : "R5", op_done, fin_e);
        if (fin_e) begin
            chk(m_fin_erase ? "R6" : "R5", commit_erase, m_fin_erase);
            chk(m_fin_erase ? "R6" : "R5", commit_data, m_fin_erase ? 8'hFF : (m_pold & m_pdata));
            if (!m_fin_erase) chk("R5", commit_addr, m_paddr);
        end
        chk(rst_n ? "R9" : "R1", rd_data_oe, rst_n && rd_en);
        if (rst_n && rd_en) begin
            e = mem[rd_addr];
            if (busy_e) begin
                e[DW-2] = m_tgl;
                if (m_mode == 1) e[DW-1] = (rd_addr == m_paddr) ? ~m_pdata[DW-1] : mem[rd_addr][DW-1];
                else e[DW-1] = 1'b0;
            end
            chk(busy_e ? "R7" : "R9", rd_data[DW-1], e[DW-1]);
            chk(busy_e ? "R8" : "R9", rd_data[DW-2], e[DW-2]);
            chk("R9", rd_data[DW-3:0], e[DW-3:0]);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic start_prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit also_erase);
        prog_start = 1'b1; prog_addr = a; prog_data = d; prog_old = mem[a];
        erase_start = also_erase;
        step();
        prog_start = 1'b0; erase_start = 1'b0;
    endtask

    task automatic start_erase();
        erase_start = 1'b1;
        step();
        erase_start = 1'b0;
    endtask

    // counts busy cycles while issuing spaced reads that alternate between two addresses
    task automatic run_busy(input string tag, input int exp_len,
                            input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                            input logic [AW-1:0] stray_addr, input bit stray);
        int n = 0;
        int k = 0;
        forever begin
            @(negedge clk);
            if (!ryby_oe) break;
            n++;
            step();
            if (k[0] == 1'b0) begin
                rd_en = 1'b1;
                rd_addr = k[1] ? a1 : a0;
            end else begin
                rd_en = 1'b0;
            end
            if (stray && n == 2) begin
                prog_start = 1'b1; prog_addr = stray_addr; prog_data = 8'h00; prog_old = mem[stray_addr];
            end else begin
                prog_start = 1'b0;
            end
            k++;
        end
        rd_en = 1'b0;
        chk(tag, n, exp_len);
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        chk(tag, rd_data, exp);
        step();
        rd_en = 1'b0;
        step();
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = 8'(i * 37 + 11);
        rd_en = 1'b1; rd_addr = 8'd5;
        repeat (3) step();
        @(negedge clk);
        chk("R1", rd_data_oe, 1'b0);
        chk("R1", ryby_oe, 1'b0);
        rst_n = 1'b1;
        step();
        rd_en = 1'b0;
        step();
        read_expect(8'd5, 8'(5 * 37 + 11), "R9");

        // program with polling and toggle reads on the pending and another address
        start_prog(8'd5, 8'h3C, 1'b0);
        run_busy("R2", PC, 8'd5, 8'd9, 8'd0, 1'b0);
        step(); step();
        read_expect(8'd5, 8'(5 * 37 + 11) & 8'h3C, "R5");

        // erase with a stray program start during busy
        start_erase();
        run_busy("R3", EC, 8'd7, 8'd5, 8'd33, 1'b1);
        step(); step();
        read_expect(8'd33, 8'hFF, "R10");
        read_expect(8'd5, 8'hFF, "R6");

        // simultaneous starts: program wins
        start_prog(8'd20, 8'h0F, 1'b1);
        run_busy("R11", PC, 8'd20, 8'd21, 8'd0, 1'b0);
        step(); step();
        read_expect(8'd20, 8'h0F, "R11");
        read_expect(8'd21, 8'hFF, "R11");

        // back-to-back: erase issued in the finish cycle
        start_prog(8'd40, 8'hA5, 1'b0);
        run_busy("R2", PC, 8'd40, 8'd41, 8'd0, 1'b0);
        #1;
        erase_start = 1'b1;
        step();
        erase_start = 1'b0;
        @(negedge clk);
        chk("R12", ryby_oe, 1'b1);
        run_busy("R3", EC - 1, 8'd40, 8'd3, 8'd0, 1'b0);
        step(); step();
        read_expect(8'd40, 8'hFF, "R12");

        // abort by reset during a program
        start_prog(8'd50, 8'h00, 1'b0);
        step(); step();
        rst_n = 1'b0;
        rd_en = 1'b1; rd_addr = 8'd50;
        @(negedge clk);
        chk("R1", rd_data_oe, 1'b0);
        chk("R1", ryby_oe, 1'b0);
        step();
        rst_n = 1'b1;
        rd_en = 1'b0;
        repeat (PC + 3) step();
        read_expect(8'd50, 8'hFF, "R1");

        repeat (3) step();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule